// File: doc/BRIEF.md
# SMBus Target with Alert Response and Bus Timeout

This block is the serial-bus front end of a small register-based peripheral. It watches the open-drain clock and data lines, answers its own 7-bit address, and pulls data low through an output-enable pin. Two write forms are supported. A one-byte write loads a register pointer. A two-byte write loads the pointer and then stores a data byte at that pointer. A one-byte read returns the register at the current pointer, and the pointer keeps its value from one transaction to the next. The small register file holds a few general registers, a configuration byte at pointer 0x40 and a status byte at pointer 0x41.

An internal alert request latches a pending flag, and the flag drives a shared active-low alert line. A host that sees the alert line low reads from the alert response address. Every pending target answers with its own address, and open-drain arbitration leaves the lowest address on the bus. A target that loses arbitration stops driving, and its flag stays set.

A watchdog on bus inactivity returns the state machine to idle and lets go of the data line if the bus stalls in the middle of a transaction. Software can turn this watchdog off.

Top module: `smb_alert_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `alert_n` is 1, the pointer is 0x00, every general register and the configuration byte are 0x00, and the bus watchdog is enabled.
- R2: A write addressed to the own address (R/W bit = 0) with two data bytes is ACKed on every byte. The first byte becomes the pointer. The second byte is stored at that pointer in register 0..REG_NUM-1 or in the configuration byte (0x40). At any other pointer the stored value is dropped and later reads return 0x00.
- R3: A read addressed to the own address (R/W bit = 1) is ACKed. The target then shifts out, MSB first, the byte at the current pointer. The pointer can be set by a one-byte or a two-byte write, and it persists across any number of reads.
- R4: An address byte that matches neither the own address (with R/W = 0 or 1) nor the alert response address with R/W = 1 gets no ACK. The target then drives nothing and stores nothing until the next START, and a later STOP ends the transaction.
- R5: When `alert_req` is high, `alert_n` is low from the next clock onward. It stays low after `alert_req` drops, for as long as the pending flag is set.
- R6: A read of address 0x0C (binary 0001100, R/W = 1) is ACKed only while the pending flag is set. The target then returns the byte {own_addr, 0}. A write to 0x0C, or a read of 0x0C with no pending flag, gets no ACK.
- R7: While it answers 0x0C, a target that leaves a bit released (logic 1) but samples SDA low at the rising edge of SCL stops driving for the rest of the byte. Its pending flag stays set.
- R8: The pending flag clears only at the master-acknowledge bit of a read at pointer 0x41, and only if `alert_req` is low at that moment. Answering 0x0C does not clear it. Bit 0 of the status byte (0x41) reads as `alert_req`, and the other bits read as 0.
- R9: When the target is not idle and neither synchronized line changes for TIMEOUT_US microseconds, the target releases SDA and returns to idle.
- R10: Bit 6 of the configuration byte (0x40) disables the bus watchdog when set. With the bit set, a stalled transaction keeps its state, including an ACK that is being driven. The configuration byte reads back as it was written.
- R11: `sda_oe` goes from 0 to 1 only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| own_addr | input | 7 | 7-bit device address of this target |
| alert_req | input | 1 | Alert condition from the peripheral core |
| alert_n | output | 1 | Active-low alert output, open-drain at the pad |

## Verification
The assertions assume that SCL stays low for many system clocks after each falling edge. Without that, a drive that starts three clocks after the edge could land in a high phase. They also assume the bus levels change slowly enough for the two-stage synchronizer to catch every transition. The bench meets both assumptions: its master changes one line at a time, every ten clocks, at quarter-bit points, and it changes data only in the middle of the low phase. A second open-drain model on SDA plays the competing target during alert arbitration. That model changes its level at the same points as the master.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } smb_state_e;

  localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;
  localparam logic [7:0] CFG_PTR         = 8'h40;
  localparam logic [7:0] STAT_PTR        = 8'h41;
  localparam int         WDOG_OFF_BIT    = 6;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic line_edge
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
  assign line_edge = (scl_s ^ scl_prev) | (sda_s ^ sda_prev);
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int LIMIT = 3_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = run && !restart && (cnt_q == CW'(LIMIT));

  always_comb begin
    if (!run || restart || expired) cnt_d = '0;
    else                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       timeout,
  input  logic [6:0] own_addr,
  input  logic       alert_pend,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       busy,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       stat_rd
);
  smb_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, ptr_q, ptr_d, tx_byte;
  logic [1:0] idx_q, idx_d;
  logic oe_q, oe_d, rw_q, rw_d, ara_q, ara_d;

  assign tx_byte = ara_q ? {own_addr, 1'b0} : rd_data;
  assign wr_data = {sh_q[6:0], sda_s};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    ara_d   = ara_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    wr_en   = 1'b0;
    stat_rd = 1'b0;
    if (stop_det || timeout) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          sh_d  = wr_data;
          cnt_d = cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            cnt_d = '0;
            idx_d = '0;
            rw_d  = sda_s;
            if (sh_q[6:0] == own_addr && own_addr != ALERT_RESP_ADDR) begin
              ara_d   = 1'b0;
              state_d = ST_ACK_WAIT;
            end else if (sh_q[6:0] == ALERT_RESP_ADDR && sda_s && alert_pend) begin
              ara_d   = 1'b1;
              state_d = ST_ACK_WAIT;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          oe_d    = 1'b1;
          state_d = ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            sh_d    = tx_byte;
            oe_d    = ~tx_byte[7];
            state_d = ST_TX;
          end else begin
            oe_d    = 1'b0;
            state_d = ST_RX;
          end
        end
        ST_RX: if (scl_rise) begin
          sh_d  = wr_data;
          cnt_d = cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            cnt_d = '0;
            if (idx_q != 2'd3) idx_d = idx_q + 2'd1;
            if (idx_q == 2'd0) begin
              ptr_d   = wr_data;
              state_d = ST_ACK_WAIT;
            end else if (idx_q == 2'd1) begin
              wr_en   = 1'b1;
              state_d = ST_ACK_WAIT;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_TX: if (scl_rise) begin
          if (ara_q && !oe_q && !sda_s) begin
            state_d = ST_SKIP;
          end else begin
            sh_d  = {sh_q[6:0], 1'b0};
            cnt_d = cnt_q + 4'd1;
          end
        end else if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            oe_d    = 1'b0;
            state_d = ST_MACK;
          end else begin
            oe_d = ~sh_q[7];
          end
        end
        ST_MACK: if (scl_rise) begin
          if (!ara_q && ptr_q == STAT_PTR) stat_rd = 1'b1;
          state_d = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      ara_q   <= 1'b0;
      idx_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      ara_q   <= ara_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
    end
  end

  assign sda_oe = oe_q;
  assign busy   = (state_q != ST_IDLE);
  assign ptr    = ptr_q;
endmodule

// File: rtl/smb_alert_target.sv
module smb_alert_target
  import smb_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int TIMEOUT_US  = 35_000,
  parameter int REG_NUM     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic       alert_req,
  output logic       alert_n
);
  localparam int TO_LIMIT = (CLK_HZ / 1_000_000) * TIMEOUT_US;

  logic [1:0] rst_pipe;
  logic rst_int;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, line_edge;
  logic timeout, busy, wr_en, stat_rd, todis;
  logic [7:0] ptr, wr_data, rd_data, cfg_q;
  logic alert_pend_q;
  logic [7:0] reg_val [REG_NUM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .line_edge(line_edge)
  );

  smb_idle_timer #(.LIMIT(TO_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_int), .run(busy && !todis),
    .restart(line_edge), .expired(timeout)
  );

  smb_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_int), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .timeout(timeout),
    .own_addr(own_addr), .alert_pend(alert_pend_q), .rd_data(rd_data),
    .sda_oe(sda_oe), .busy(busy), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .stat_rd(stat_rd)
  );

  for (genvar g = 0; g < REG_NUM; g++) begin : g_reg
    localparam logic [7:0] IDX = 8'(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_int) begin
      if (!rst_int)                   q <= '0;
      else if (wr_en && ptr == IDX)   q <= wr_data;
    end
    assign reg_val[g] = q;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)                      cfg_q <= '0;
    else if (wr_en && ptr == CFG_PTR)  cfg_q <= wr_data;
  end
  assign todis = cfg_q[WDOG_OFF_BIT];

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) alert_pend_q <= 1'b0;
    else          alert_pend_q <= alert_req | (alert_pend_q & ~stat_rd);
  end
  assign alert_n = ~alert_pend_q;

  always_comb begin
    rd_data = '0;
    if (ptr == CFG_PTR)       rd_data = cfg_q;
    else if (ptr == STAT_PTR) rd_data = {7'b0, alert_req};
    else begin
      for (int i = 0; i < REG_NUM; i++)
        if (ptr == 8'(i)) rd_data = reg_val[i];
    end
  end
endmodule

// File: rtl/smb_alert_target_chk.sv
module smb_alert_target_chk #(
  parameter int LIMIT = 3_500_000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_s,
  input logic sda_oe,
  input logic alert_req,
  input logic alert_n,
  input logic todis
);
  localparam int QW  = $clog2(LIMIT + 8);
  localparam int SAT = LIMIT + 4;

  logic scl_p, sda_p;
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
      quiet_q <= '0;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (todis || scl_s != scl_p || sda_s != sda_p) quiet_q <= '0;
      else if (quiet_q != QW'(SAT))                   quiet_q <= quiet_q + 1'b1;
    end
  end

  a_r11_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r5_alert_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    alert_req |=> !alert_n);

  a_r8_release_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_n) |-> !$past(alert_req));

  a_r9_stall_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q >= QW'(LIMIT + 2)) |-> !sda_oe);
endmodule

bind smb_alert_target smb_alert_target_chk #(.LIMIT(TO_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_int), .scl_s(scl_s), .sda_s(sda_s),
  .sda_oe(sda_oe), .alert_req(alert_req), .alert_n(alert_n), .todis(todis)
);

// File: tb/smb_alert_target_bench.sv
module smb_alert_target_bench;
  localparam int HQ = 10;
  localparam logic [6:0] OWN = 7'h2A;
  localparam logic [6:0] ARA = 7'h0C;
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'hA5, 8'hA5},
    {8'h01, 8'h3C, 8'h3C},
    {8'h02, 8'hFF, 8'hFF},
    {8'h03, 8'h00, 8'h00},
    {8'h07, 8'h77, 8'h00},
    {8'h40, 8'h05, 8'h05}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, sda_other, alert_req;
  logic [6:0] own_addr;
  wire sda_oe, alert_n;
  wire sda_line = sda_m & ~sda_oe & sda_other;

  smb_alert_target #(.TIMEOUT_US(20)) u_smb_alert_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .own_addr(own_addr), .alert_req(alert_req),
    .alert_n(alert_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (HQ) @(negedge clk);
  endtask

  task automatic m_start();
    scl_m = 1'b0; hq();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic m_stop();
    scl_m = 1'b0; sda_m = 1'b0; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic m_bit(input logic b, input logic oth, output logic r);
    sda_m = b; sda_other = oth; hq();
    scl_m = 1'b1; hq();
    r = sda_line; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], 1'b1, r);
    m_bit(1'b1, 1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(input logic [7:0] oth, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, oth[i], r);
      d[i] = r;
    end
    m_bit(1'b1, 1'b1, r);
  endtask

  task automatic wr2(input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    m_start(); m_wbyte({OWN, 1'b0}, a0); m_wbyte(p, a1); m_wbyte(d, a2); m_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic wr1(input logic [7:0] p, output logic ok);
    logic a0, a1;
    m_start(); m_wbyte({OWN, 1'b0}, a0); m_wbyte(p, a1); m_stop();
    ok = a0 & a1;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] oth,
                    output logic [7:0] d, output logic ack);
    m_start(); m_wbyte({a, 1'b1}, ack);
    if (ack) m_rbyte(oth, d); else d = 8'hEE;
    m_stop();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    logic ok, ack, r;
    logic [7:0] d;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; sda_other = 1'b1;
    alert_req = 1'b0; own_addr = OWN;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    chk("R1 sda_oe", {7'b0, sda_oe}, 8'h00);
    chk("R1 alert_n", {7'b0, alert_n}, 8'h01);
    rd(OWN, 8'hFF, d, ack);
    chk("R1 ptr0 read ack", {7'b0, ack}, 8'h01);
    chk("R1 ptr0 data", d, 8'h00);

    // R2 / R3 table walk
    for (int v = 0; v < NV; v++) begin
      wr2(VEC[v][23:16], VEC[v][15:8], ok);
      chk("R2 write acks", {7'b0, ok}, 8'h01);
      wr1(VEC[v][23:16], ok);
      chk("R3 pointer set acks", {7'b0, ok}, 8'h01);
      rd(OWN, 8'hFF, d, ack);
      chk("R2 readback", d, VEC[v][7:0]);
    end

    // R3 pointer persistence
    wr1(8'h01, ok);
    rd(OWN, 8'hFF, d, ack);
    chk("R3 first read", d, 8'h3C);
    rd(OWN, 8'hFF, d, ack);
    chk("R3 pointer kept", d, 8'h3C);
    wr2(8'h02, 8'h5A, ok);
    rd(OWN, 8'hFF, d, ack);
    chk("R3 pointer from write byte", d, 8'h5A);

    // R4 foreign address ignored until START
    m_start();
    m_wbyte({7'h33, 1'b0}, ack);
    chk("R4 foreign addr nack", {7'b0, ack}, 8'h00);
    m_wbyte(8'h00, ack);
    chk("R4 later byte nack", {7'b0, ack}, 8'h00);
    m_wbyte(8'h99, ack);
    m_stop();
    wr1(8'h00, ok);
    rd(OWN, 8'hFF, d, ack);
    chk("R4 reg0 untouched", d, 8'hA5);

    // R6 no pending: ARA read and ARA write not acked
    rd(ARA, 8'hFF, d, ack);
    chk("R6 ara nack idle", {7'b0, ack}, 8'h00);

    // R5 alert latch
    @(negedge clk); alert_req = 1'b1;
    @(negedge clk); alert_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 alert_n low", {7'b0, alert_n}, 8'h00);

    m_start(); m_wbyte({ARA, 1'b0}, ack); m_stop();
    chk("R6 ara write nack", {7'b0, ack}, 8'h00);

    // R7 arbitration against lower address 0x27
    rd(ARA, {7'h27, 1'b0}, d, ack);
    chk("R7 ara ack", {7'b0, ack}, 8'h01);
    chk("R7 winner byte", d, 8'h4E);
    chk("R7 still pending", {7'b0, alert_n}, 8'h00);

    // R6 sole responder
    rd(ARA, 8'hFF, d, ack);
    chk("R6 ara ack", {7'b0, ack}, 8'h01);
    chk("R6 own addr byte", d, {OWN, 1'b0});
    chk("R8 ara does not release", {7'b0, alert_n}, 8'h00);

    // R8 status read with condition present, then gone
    alert_req = 1'b1;
    wr1(8'h41, ok);
    rd(OWN, 8'hFF, d, ack);
    chk("R8 status set", d, 8'h01);
    chk("R8 held while req", {7'b0, alert_n}, 8'h00);
    alert_req = 1'b0;
    rd(OWN, 8'hFF, d, ack);
    chk("R8 status clear", d, 8'h00);
    chk("R8 released", {7'b0, alert_n}, 8'h01);

    // R9 stall during ACK
    m_start();
    for (int i = 7; i >= 0; i--) m_bit(OWN[i < 1 ? 0 : i - 1] & (i != 0), 1'b1, r);
    sda_m = 1'b1; hq();
    chk("R9 ack driven", {7'b0, sda_oe}, 8'h01);
    repeat (2300) @(negedge clk);
    chk("R9 released after stall", {7'b0, sda_oe}, 8'h00);
    m_stop();
    rd(OWN, 8'hFF, d, ack);
    chk("R9 bus usable after", d, 8'h00);

    // R10 watchdog disabled
    wr2(8'h40, 8'h40, ok);
    m_start();
    for (int i = 7; i >= 0; i--) m_bit(OWN[i < 1 ? 0 : i - 1] & (i != 0), 1'b1, r);
    sda_m = 1'b1; hq();
    repeat (2300) @(negedge clk);
    chk("R10 ack still driven", {7'b0, sda_oe}, 8'h01);
    m_bit(1'b1, 1'b1, r);
    chk("R10 ack seen", {7'b0, r}, 8'h00);
    m_stop();
    wr1(8'h40, ok);
    rd(OWN, 8'hFF, d, ack);
    chk("R10 cfg readback", d, 8'h40);

    done = 1'b1;
    report();
    $finish;
  end
endmodule